// File: doc/BRIEF.md
# Per-Area Bus Cycle Wait-State Controller

This block decides how many clock states a single bus access lasts. At request time it takes:

- the kind of memory region being addressed,
- the area number,
- the access direction,
- the configuration that applies to that access: per-area wait-enable bits, a write pitch bit and a long-wait field.

From these it computes a base state count and decides whether the external WAIT input may lengthen the access. The result is latched, and the access then runs through its states. `cyc_active` is high in every state of the access. `cyc_done` is high in the final state only.

The sequencer has three states:

- `ST_IDLE`: no access in progress.
- `ST_RUN`: counting states, with two or more states still to go.
- `ST_LAST`: the final state.

The transitions are:

- `ST_IDLE -> ST_RUN`: a request is accepted and its base count is at least 2.
- `ST_IDLE -> ST_LAST`: a request is accepted and its base count is 1.
- `ST_RUN -> ST_RUN`: either a countdown step, or a wait insertion when WAIT is sampled high.
- `ST_RUN -> ST_LAST`: two states remained and no wait is inserted.
- `ST_LAST -> ST_IDLE`: always.

A bus controller uses the block by raising `req_valid` while the block is idle. It follows the access with `cyc_active` and ends it on `cyc_done`.

Top module: `bus_wait_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no request, `cyc_active` and `cyc_done` are 0.
- R2: An access to on-chip ROM (kind 0) or on-chip RAM (kind 1) lasts exactly 1 state in either direction, whatever the value of WAIT.
- R3: An access to on-chip peripheral space (kind 2) lasts exactly 3 states in either direction, whatever the value of WAIT.
- R4: An access to multiplexed I/O space (kind 3) lasts 4 states plus the WAIT-inserted states, in either direction.
- R5: A read of a normal external area (kind 4) lasts 1 state and ignores WAIT when bit `cfg_wait_bits[req_area]` is 0. When that bit is 1, the read lasts 2 states plus the WAIT-inserted states.
- R6: A write to a normal external area (kind 4) lasts 2 states plus the WAIT-inserted states, whatever `cfg_wait_bits` and `cfg_write_wait` hold.
- R7: For a read of a long-wait area (kind 5), L is `cfg_long_wait` + 1, so field values 0 to 3 give 1 to 4 extra states. With `cfg_wait_bits[req_area]` at 0, the read lasts 1 + L states and ignores WAIT. With the bit at 1, it lasts 1 + L states plus the WAIT-inserted states.
- R8: A write to a long-wait area (kind 5) lasts 1 + L states plus the WAIT-inserted states, whatever the area's wait bit holds.
- R9: For a DRAM column cycle (kind 6), the pitch bit is `cfg_wait_bits[req_area]` for a read and `cfg_write_wait` for a write. A pitch bit of 0 (short pitch) gives 1 state with WAIT ignored. A pitch bit of 1 (long pitch) gives 2 states plus the WAIT-inserted states.
- R10: WAIT is sampled only in the state before the final state. Each time it is sampled high there, one more state is inserted and WAIT is sampled again. A high WAIT in any earlier state has no effect.
- R11: `cyc_done` is high for exactly one clock, in the final state of the access. A request is accepted only while the block is idle, that is in the cycle after `cyc_done` or later. A request raised while an access is in progress is ignored.
- R12: Kind, area, direction and configuration are captured on the accepting edge. Changes to any of them during the access do not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, sampled while idle |
| req_area | input | AREA_W | Area number, used to select the per-area wait bit |
| req_kind | input | 3 | Region kind: 0 ROM, 1 RAM, 2 peripheral, 3 multiplexed I/O, 4 normal external, 5 long-wait external, 6 DRAM |
| req_write | input | 1 | 1 for a write, 0 for a read |
| cfg_wait_bits | input | NUM_AREAS | Per-area wait-enable bit; for DRAM reads it is the pitch bit |
| cfg_write_wait | input | 1 | Pitch bit for DRAM writes |
| cfg_long_wait | input | LW_W | Long-wait field; value n adds n + 1 states |
| wait_in | input | 1 | External WAIT request |
| cyc_active | output | 1 | High in every state of an access |
| cyc_done | output | 1 | High in the final state of an access |

## Verification
An access accepted at a rising edge has its first state in the following cycle. From that point the expected level of `cyc_active` and `cyc_done` is known for every cycle index: active while the index is below the expected length, and done at the last index. The bench's reference model computes that length from the requirements, including the exact number of states at which WAIT is held high at the sample point. It compares both outputs at each falling edge, from the first state through two cycles beyond the expected end. Stray WAIT pulses in earlier states, requests raised during an access, and changed configuration during an access are all placed inside that same window, so any effect they have shows up as a length mismatch.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    typedef enum logic [2:0] {
        AK_ROM      = 3'd0,
        AK_RAM      = 3'd1,
        AK_PERIPH   = 3'd2,
        AK_MUXIO    = 3'd3,
        AK_EXT      = 3'd4,
        AK_EXTLONG  = 3'd5,
        AK_DRAM     = 3'd6,
        AK_RSVD     = 3'd7
    } area_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LAST = 2'd2
    } cyc_state_e;

endpackage

// File: rtl/bwc_count_calc.sv
module bwc_count_calc
    import bwc_pkg::*;
#(
    parameter int NUM_AREAS = 8,
    parameter int AREA_W    = 3,
    parameter int LW_W      = 2,
    parameter int CNT_W     = 3
) (
    input  logic [2:0]           kind,
    input  logic [AREA_W-1:0]    area,
    input  logic                 is_write,
    input  logic [NUM_AREAS-1:0] wait_bits,
    input  logic                 write_wait,
    input  logic [LW_W-1:0]      long_wait,
    output logic [CNT_W-1:0]     base_cnt,
    output logic                 wait_en
);

    logic       area_bit;
    logic       pitch_long;
    logic [CNT_W-1:0] long_cnt;
    area_kind_e k;

    always_comb begin
        k          = area_kind_e'(kind);
        area_bit   = (int'(area) < NUM_AREAS) ? wait_bits[area] : 1'b0;
        pitch_long = is_write ? write_wait : area_bit;
        // one base state plus (field + 1) long-wait states
        long_cnt   = CNT_W'(long_wait) + CNT_W'(2);
    end

    always_comb begin
        base_cnt = CNT_W'(1);
        wait_en  = 1'b0;
        unique case (k)
            AK_ROM, AK_RAM: begin
                base_cnt = CNT_W'(1);
                wait_en  = 1'b0;
            end
            AK_PERIPH: begin
                base_cnt = CNT_W'(3);
                wait_en  = 1'b0;
            end
            AK_MUXIO: begin
                base_cnt = CNT_W'(4);
                wait_en  = 1'b1;
            end
            AK_EXT: begin
                if (is_write || area_bit) begin
                    base_cnt = CNT_W'(2);
                    wait_en  = 1'b1;
                end else begin
                    base_cnt = CNT_W'(1);
                    wait_en  = 1'b0;
                end
            end
            AK_EXTLONG: begin
                base_cnt = long_cnt;
                wait_en  = is_write || area_bit;
            end
            AK_DRAM: begin
                base_cnt = pitch_long ? CNT_W'(2) : CNT_W'(1);
                wait_en  = pitch_long;
            end
            AK_RSVD: begin
                base_cnt = CNT_W'(1);
                wait_en  = 1'b0;
            end
            default: begin
                base_cnt = CNT_W'(1);
                wait_en  = 1'b0;
            end
        endcase
    end

    // R10: a WAIT-extendable access always has a state before its final one
    always_comb begin
        p_waitable_min_r10: assert (!wait_en || base_cnt >= CNT_W'(2))
            else $error("waitable access shorter than two states");
    end

endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
    import bwc_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] base_cnt,
    input  logic             wait_en,
    input  logic             wait_in,
    output logic             cyc_active,
    output logic             cyc_done
);

    cyc_state_e       state, state_nxt;
    logic [CNT_W-1:0] rem, rem_nxt;
    logic             wen_q, wen_nxt;
    logic             extend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rem   <= '0;
            wen_q <= 1'b0;
        end else begin
            state <= state_nxt;
            rem   <= rem_nxt;
            wen_q <= wen_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        rem_nxt   = rem;
        wen_nxt   = wen_q;
        extend    = (rem == CNT_W'(2)) && wen_q && wait_in;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    rem_nxt   = base_cnt;
                    wen_nxt   = wait_en;
                    state_nxt = (base_cnt == CNT_W'(1)) ? ST_LAST : ST_RUN;
                end
            end
            ST_RUN: begin
                if (!extend) begin
                    rem_nxt   = rem - CNT_W'(1);
                    state_nxt = (rem == CNT_W'(2)) ? ST_LAST : ST_RUN;
                end
            end
            ST_LAST: begin
                rem_nxt   = '0;
                state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        cyc_active = (state != ST_IDLE);
        cyc_done   = (state == ST_LAST);
    end

    // R11: done lasts one clock and closes the access
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);
    p_done_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_active);
    // R11: an idle request always starts an access
    p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_active && req_valid) |=> cyc_active);
    // R10: a high WAIT at the sample point holds the countdown
    p_wait_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && rem == CNT_W'(2) && wen_q && wait_in)
            |=> (state == ST_RUN && rem == CNT_W'(2)));
    // R10: WAIT is never honoured by an access that ignores it
    p_nowait_counts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !wen_q) |=> (rem == $past(rem) - CNT_W'(1)));

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int NUM_AREAS = 8,
    parameter int LW_W      = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [$clog2(NUM_AREAS)-1:0]  req_area,
    input  logic [2:0]                    req_kind,
    input  logic                          req_write,
    input  logic [NUM_AREAS-1:0]          cfg_wait_bits,
    input  logic                          cfg_write_wait,
    input  logic [LW_W-1:0]               cfg_long_wait,
    input  logic                          wait_in,
    output logic                          cyc_active,
    output logic                          cyc_done
);

    localparam int AREA_W   = $clog2(NUM_AREAS);
    localparam int LW_MAX   = 1 << LW_W;
    localparam int MAX_BASE = 1 + LW_MAX;
    localparam int CNT_W    = $clog2(MAX_BASE + 1);

    logic [CNT_W-1:0] base_cnt;
    logic             wait_en;

    bwc_count_calc #(
        .NUM_AREAS (NUM_AREAS),
        .AREA_W    (AREA_W),
        .LW_W      (LW_W),
        .CNT_W     (CNT_W)
    ) u_calc (
        .kind       (req_kind),
        .area       (req_area),
        .is_write   (req_write),
        .wait_bits  (cfg_wait_bits),
        .write_wait (cfg_write_wait),
        .long_wait  (cfg_long_wait),
        .base_cnt   (base_cnt),
        .wait_en    (wait_en)
    );

    bwc_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .base_cnt   (base_cnt),
        .wait_en    (wait_en),
        .wait_in    (wait_in),
        .cyc_active (cyc_active),
        .cyc_done   (cyc_done)
    );

endmodule

// File: tb/sim_bus_wait_ctrl.sv
`timescale 1ns/1ps
module sim_bus_wait_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [2:0] req_area;
    logic [2:0] req_kind;
    logic       req_write;
    logic [7:0] cfg_wait_bits;
    logic       cfg_write_wait;
    logic [1:0] cfg_long_wait;
    logic       wait_in;
    logic       cyc_active;
    logic       cyc_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_wait_ctrl u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_area       (req_area),
        .req_kind       (req_kind),
        .req_write      (req_write),
        .cfg_wait_bits  (cfg_wait_bits),
        .cfg_write_wait (cfg_write_wait),
        .cfg_long_wait  (cfg_long_wait),
        .wait_in        (wait_in),
        .cyc_active     (cyc_active),
        .cyc_done       (cyc_done)
    );

    // reference: base length and whether WAIT counts, straight from the requirements
    function automatic int ref_base(input int kind, input int area, input bit wr,
                                    input logic [7:0] bits, input bit ww, input int lw);
        case (kind)
            0, 1: return 1;
            2: return 3;
            3: return 4;
            4: return (wr || bits[area]) ? 2 : 1;
            5: return 2 + lw;
            6: return (wr ? ww : bits[area]) ? 2 : 1;
            default: return 1;
        endcase
    endfunction

    function automatic bit ref_waitable(input int kind, input int area, input bit wr,
                                        input logic [7:0] bits, input bit ww);
        case (kind)
            3: return 1'b1;
            4: return wr || bits[area];
            5: return wr || bits[area];
            6: return wr ? ww : bits[area];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input int idx, input bit exp_act, input bit exp_done);
        checks++;
        if (cyc_active !== exp_act || cyc_done !== exp_done) begin
            errors++;
            $display("FAIL %s: state %0d active=%0b done=%0b expected active=%0b done=%0b",
                     req, idx, cyc_active, cyc_done, exp_act, exp_done);
        end
    endtask

    // one access: k = number of high WAIT samples at the sample point
    task automatic access(input string req, input int kind, input int area, input bit wr,
                          input logic [7:0] bits, input bit ww, input int lw, input int k);
        int  base;
        bit  wable;
        int  total;
        base  = ref_base(kind, area, wr, bits, ww, lw);
        wable = ref_waitable(kind, area, wr, bits, ww);
        total = base + (wable ? k : 0);
        @(negedge clk);
        req_valid      = 1'b1;
        req_kind       = 3'(kind);
        req_area       = 3'(area);
        req_write      = wr;
        cfg_wait_bits  = bits;
        cfg_write_wait = ww;
        cfg_long_wait  = 2'(lw);
        wait_in        = 1'b0;
        for (int i = 0; i < total + 2; i++) begin
            @(negedge clk);
            check(req, i, i < total, i == total - 1);
            if (i == 0) begin
                // R11/R12: request and config disturbed during the access
                req_valid      = 1'b1;
                req_kind       = 3'd3;
                req_write      = ~wr;
                cfg_wait_bits  = ~bits;
                cfg_write_wait = ~ww;
                cfg_long_wait  = ~cfg_long_wait;
            end else begin
                req_valid = 1'b0;
            end
            if (wable)
                wait_in = ((i >= base - 2) && (i < base - 2 + k)) ||
                          ((i < base - 2) && (i % 2 == 0));
            else
                wait_in = (i < total);
        end
        wait_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_area = '0; req_kind = '0; req_write = 1'b0;
        cfg_wait_bits = '0; cfg_write_wait = 1'b0; cfg_long_wait = '0; wait_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", 1, 1'b0, 1'b0);

        access("R2", 0, 0, 0, 8'hFF, 1, 3, 2);
        access("R2", 1, 7, 1, 8'hFF, 1, 3, 2);
        access("R3", 2, 5, 0, 8'hFF, 1, 0, 3);
        access("R3", 2, 5, 1, 8'h00, 0, 0, 3);
        access("R4", 3, 6, 0, 8'h00, 0, 0, 0);
        access("R4", 3, 6, 1, 8'h00, 0, 0, 3);
        access("R5", 4, 3, 0, 8'hF7, 0, 0, 2);
        access("R5", 4, 3, 0, 8'h08, 0, 0, 0);
        access("R5", 4, 3, 0, 8'h08, 0, 0, 2);
        access("R6", 4, 1, 1, 8'h00, 0, 0, 1);
        access("R6", 4, 4, 1, 8'hFF, 1, 2, 0);
        access("R7", 5, 0, 0, 8'h00, 0, 0, 3);
        access("R7", 5, 2, 0, 8'h00, 0, 3, 3);
        access("R7", 5, 6, 0, 8'h40, 0, 1, 2);
        access("R8", 5, 2, 1, 8'h00, 0, 2, 1);
        access("R8", 5, 0, 1, 8'hFF, 1, 0, 0);
        access("R9", 6, 1, 0, 8'hFD, 1, 0, 2);
        access("R9", 6, 1, 0, 8'h02, 0, 0, 1);
        access("R9", 6, 1, 1, 8'hFF, 0, 0, 2);
        access("R9", 6, 1, 1, 8'h00, 1, 0, 2);
        access("R10", 3, 6, 0, 8'h00, 0, 0, 5);
        access("R10", 5, 0, 1, 8'h00, 0, 3, 4);
        access("R11", 0, 0, 0, 8'h00, 0, 0, 0);
        access("R12", 5, 0, 0, 8'h00, 0, 3, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule